// File: doc/BRIEF.md
# Universal serial shift unit

A small serial engine for bit-level transfers. An 8-bit shift register and a 4-bit counter advance together from one selected clock source. Each shift samples the serial input pin and moves the register left, so software can load a byte, let the clock run, and read the received byte back through a two-address bus port. The counter tracks progress and raises a sticky interrupt flag when it wraps.

Three clock sources can be chosen: an external serial clock pin, a one-cycle timer-overflow strobe, or a one-cycle software strobe. The external pin is brought into the system clock domain with a synchronizer. Both of its edges advance the counter, so one byte is 16 counts; only its rising edge shifts. The register's top bit goes to the pins through an output latch that loads on the falling edge of the external clock. Data out therefore changes half a serial period away from the sampling edge. A wire-mode input routes that bit either to a push-pull data-out pin or to an open-drain drive-low enable for a shared data line.

Top module: `ser_shift_unit`

## Requirements
- R1: After reset, the data register, counter and flag are 0, `dout_3w` is 0, `sda_drive_low` is 0 and `ovf_irq` is 0.
- R2: Reads with `bus_addr`=0 return the data register. Reads with `bus_addr`=1 return status: bit 7 is the flag, bits 6:4 are 0 and bits 3:0 are the counter. A status write loads the counter from `bus_wdata[3:0]`. It clears the flag when `bus_wdata[7]` is 1 and leaves the flag unchanged when bit 7 is 0.
- R3: Each shift event moves the data register left by one and places the `di_pin` value into bit 0.
- R4: With `clk_src`=0 (external pin), a synchronized rising edge of `sck_pin` shifts once and counts once, and a falling edge counts once without shifting. One full byte of 8 clock periods leaves the counter at 0 and sets the flag.
- R5: A counter step from 15 to 0 sets the flag. The flag stays set, and `ovf_irq` stays high, until a status write with bit 7 set.
- R6: With `clk_src`=1 (timer) or 2 (software), each one-cycle pulse on `tmr_ovf` or `sw_strobe` respectively shifts once and counts once. Pulses on the source that is not selected change nothing. With `clk_src`=3 nothing advances.
- R7: With the external source, the output latch loads the register's bit 7 only on a synchronized falling edge of `sck_pin`. With any other source, it takes bit 7 one clock after the register changes.
- R8: With `wire_mode`=0, the latched bit drives `dout_3w` and `sda_drive_low` is 0. With `wire_mode`=1, `sda_drive_low` is the inverse of the latched bit and `dout_3w` is 0.
- R9: A bus write to the data register or to the counter in the same cycle as a shift or count event takes priority over that event for the register written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 1 | 0 selects data, 1 selects status/counter |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data (combinational) |
| wire_mode | input | 1 | 0 push-pull data out, 1 open-drain data line |
| clk_src | input | 2 | 0 pin, 1 timer, 2 software, 3 stopped |
| sck_pin | input | 1 | External serial clock (asynchronous) |
| di_pin | input | 1 | Serial data input |
| tmr_ovf | input | 1 | Timer overflow strobe |
| sw_strobe | input | 1 | Software clock strobe |
| dout_3w | output | 1 | Push-pull serial data out |
| sda_drive_low | output | 1 | Drive-low enable for the open-drain data line |
| ovf_irq | output | 1 | Counter overflow interrupt (sticky flag) |

## Verification
The bench builds the unit with its default parameters: an 8-bit data register, a 4-bit counter and a two-stage synchronizer. With these, a full 16-edge external byte and the 15-to-0 wrap fall within a short run. The two-stage synchronizer fixes the latency from a pin edge to its effect at three clocks. The bench therefore holds each `sck_pin` level for four clocks, which lets it observe the output latch before and after the falling edge.

// File: rtl/ser_pkg.sv
// Shared types of the universal serial shift unit.
// Assumes: clock-source codes are fixed by the top-level port encoding.
package ser_pkg;

    typedef enum logic [1:0] {
        SRC_PIN   = 2'd0,
        SRC_TIMER = 2'd1,
        SRC_SOFT  = 2'd2,
        SRC_NONE  = 2'd3
    } src_e;

    typedef struct packed {
        logic shift;   // move data register and sample DI
        logic count;   // advance the counter
        logic latch;   // output latch enable
    } evt_t;

endpackage

// File: rtl/ser_clk_sel.sv
// Clock-source selection. Synchronizes the external serial clock,
// detects both of its edges and turns the chosen source into
// shift / count / latch events for one system clock each.
// Assumes: tmr_ovf and sw_strobe are already synchronous one-cycle pulses.
module ser_clk_sel
    import ser_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  src_e src,
    input  logic sck_pin,
    input  logic tmr_ovf,
    input  logic sw_strobe,
    output evt_t evt
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   sck_s;
    logic                   rise;
    logic                   fall;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            // Single-flop capture of the pin.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= sck_pin;
            end
        end else begin : g_syncn
            // Shift chain synchronizing the pin.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], sck_pin};
            end
        end
    endgenerate

    assign sck_s = sync_q[SYNC_STAGES-1];

    // Previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sck_s;
    end

    assign rise = sck_s & ~prev_q;
    assign fall = ~sck_s & prev_q;

    // Map the selected source to events.
    always_comb begin
        evt = '0;
        unique case (src)
            SRC_PIN: begin
                evt.shift = rise;
                evt.count = rise | fall;
                evt.latch = fall;
            end
            SRC_TIMER: begin
                evt.shift = tmr_ovf;
                evt.count = tmr_ovf;
                evt.latch = 1'b1;
            end
            SRC_SOFT: begin
                evt.shift = sw_strobe;
                evt.count = sw_strobe;
                evt.latch = 1'b1;
            end
            default: begin
                evt.latch = 1'b1;
            end
        endcase
    end

    // R4: the two edge detectors never fire together
    a_r4_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall));

    // R6: a software source without its strobe does not shift
    a_r6_soft_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_SOFT && !sw_strobe) |-> !evt.shift);

    // R6: a stopped source never counts
    a_r6_none_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_NONE) |-> !evt.count);

endmodule

// File: rtl/ser_shifter.sv
// Data shift register and output latch. Shifts left with DI into the
// LSB on a shift event; the bus write has priority. The output latch
// holds the MSB and loads only when its enable is high.
// Assumes: at most one shift event per clock.
module ser_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              latch_en,
    input  logic              di,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] data_q,
    output logic              out_bit
);

    // Data register: bus write, else shift.
    always_ff @(posedge clk) begin
        if (!rst_n)        data_q <= '0;
        else if (wr_en)    data_q <= wdata;
        else if (shift_en) data_q <= {data_q[DATA_W-2:0], di};
    end

    // Output latch: capture the MSB when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_bit <= 1'b0;
        else if (latch_en) out_bit <= data_q[DATA_W-1];
    end

    // R3: shift moves left and takes DI into bit 0
    a_r3_shift_left: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !wr_en) |=> data_q == {$past(data_q[DATA_W-2:0]), $past(di)});

    // R7: the latch holds when not enabled
    a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en |=> $stable(out_bit));

    // R9: bus write wins over a shift
    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> data_q == $past(wdata));

endmodule

// File: rtl/ser_counter.sv
// Edge/bit counter with sticky overflow flag. Counts up on each count
// event, wraps to zero and sets the flag; a bus write loads the counter
// (priority) and may clear the flag.
// Assumes: clr_flag is only asserted together with wr_en.
module ser_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wdata,
    input  logic             clr_flag,
    output logic [CNT_W-1:0] cnt_q,
    output logic             flag_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic wrap;

    assign wrap = count_en & ~wr_en & (cnt_q == CNT_MAX);

    // Counter: bus load, else increment.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (wr_en)    cnt_q <= wdata;
        else if (count_en) cnt_q <= cnt_q + 1'b1;
    end

    // Sticky flag: set on wrap, cleared by a write with the clear bit.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (wrap)     flag_q <= 1'b1;
        else if (clr_flag) flag_q <= 1'b0;
    end

    // R4: each count event steps the counter by one
    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && !wr_en) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    // R5: wrap from the top value sets the flag
    a_r5_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && !wr_en && cnt_q == CNT_MAX) |=> flag_q);

    // R5: flag holds without a bus write
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !wr_en) |=> flag_q);

endmodule

// File: rtl/ser_shift_unit.sv
// Universal serial shift unit, top level. Bus decode for the data and
// status addresses, clock-source selection, shift register, counter and
// wire-mode routing of the latched output bit.
// Assumes: DATA_W >= CNT_W + 2 so the status word has padding bits.
module ser_shift_unit
    import ser_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wire_mode,
    input  logic [1:0]        clk_src,
    input  logic              sck_pin,
    input  logic              di_pin,
    input  logic              tmr_ovf,
    input  logic              sw_strobe,
    output logic              dout_3w,
    output logic              sda_drive_low,
    output logic              ovf_irq
);

    localparam int PAD_W = DATA_W - 1 - CNT_W;

    evt_t              evt;
    logic [DATA_W-1:0] data_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              flag_q;
    logic              out_bit;
    logic              wr_data;
    logic              wr_stat;
    logic              clr_flag;

    assign wr_data  = bus_wr & ~bus_addr;
    assign wr_stat  = bus_wr &  bus_addr;
    assign clr_flag = wr_stat & bus_wdata[DATA_W-1];

    ser_clk_sel #(
        .SYNC_STAGES(SYNC_STAGES)
    ) i_clk_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src_e'(clk_src)),
        .sck_pin  (sck_pin),
        .tmr_ovf  (tmr_ovf),
        .sw_strobe(sw_strobe),
        .evt      (evt)
    );

    ser_shifter #(
        .DATA_W(DATA_W)
    ) i_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(evt.shift),
        .latch_en(evt.latch),
        .di      (di_pin),
        .wr_en   (wr_data),
        .wdata   (bus_wdata),
        .data_q  (data_q),
        .out_bit (out_bit)
    );

    ser_counter #(
        .CNT_W(CNT_W)
    ) i_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_en(evt.count),
        .wr_en   (wr_stat),
        .wdata   (bus_wdata[CNT_W-1:0]),
        .clr_flag(clr_flag),
        .cnt_q   (cnt_q),
        .flag_q  (flag_q)
    );

    // Read mux for the two bus addresses.
    always_comb begin
        if (bus_addr) bus_rdata = {flag_q, {PAD_W{1'b0}}, cnt_q};
        else          bus_rdata = data_q;
    end

    // Route the latched bit to the pin chosen by wire mode.
    always_comb begin
        if (wire_mode) begin
            dout_3w       = 1'b0;
            sda_drive_low = ~out_bit;
        end else begin
            dout_3w       = out_bit;
            sda_drive_low = 1'b0;
        end
    end

    assign ovf_irq = flag_q;

    // R8: in push-pull mode the open-drain line is released
    a_r8_line_released: assert property (@(posedge clk) disable iff (!rst_n)
        !wire_mode |-> !sda_drive_low);

    // R8: at most one pin is active
    a_r8_one_pin: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dout_3w, sda_drive_low}));

    // R2: a status write with the clear bit and no wrap leaves the flag low
    a_r2_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
        clr_flag |=> !ovf_irq);

endmodule

// File: tb/test_ser_shift_unit.sv
// Self-checking bench for ser_shift_unit.
module test_ser_shift_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       wire_mode = 1'b0;
    logic [1:0] clk_src = 2'd2;
    logic       sck_pin = 1'b0;
    logic       di_pin = 1'b0;
    logic       tmr_ovf = 1'b0;
    logic       sw_strobe = 1'b0;
    logic       dout_3w;
    logic       sda_drive_low;
    logic       ovf_irq;

    int n_checks = 0;
    int n_fails  = 0;

    // {di, expected data, expected counter} per software strobe (R3, R6)
    localparam logic [12:0] VEC [8] = '{
        {1'b1, 8'h01, 4'd1}, {1'b1, 8'h03, 4'd2},
        {1'b0, 8'h06, 4'd3}, {1'b0, 8'h0C, 4'd4},
        {1'b0, 8'h18, 4'd5}, {1'b0, 8'h30, 4'd6},
        {1'b1, 8'h61, 4'd7}, {1'b1, 8'hC3, 4'd8}
    };

    always #5 clk = ~clk;

    ser_shift_unit i_ser_shift_unit (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wire_mode(wire_mode),
        .clk_src(clk_src), .sck_pin(sck_pin), .di_pin(di_pin),
        .tmr_ovf(tmr_ovf), .sw_strobe(sw_strobe), .dout_3w(dout_3w),
        .sda_drive_low(sda_drive_low), .ovf_irq(ovf_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic sw_pulse(input logic d);
        @(negedge clk);
        di_pin = d; sw_strobe = 1'b1;
        @(negedge clk);
        sw_strobe = 1'b0;
    endtask

    task automatic tmr_pulse(input logic d);
        @(negedge clk);
        di_pin = d; tmr_ovf = 1'b1;
        @(negedge clk);
        tmr_ovf = 1'b0;
    endtask

    task automatic sck_level(input logic v, input logic d);
        @(negedge clk);
        di_pin = d; sck_pin = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(1'b0, v); check("R1 data", v, 8'h00);
        rd(1'b1, v); check("R1 status", v, 8'h00);
        check("R1 dout", {7'd0, dout_3w}, 8'h00);
        check("R1 sda", {7'd0, sda_drive_low}, 8'h00);
        check("R1 irq", {7'd0, ovf_irq}, 8'h00);

        // R3/R6: vector walk with the software source
        clk_src = 2'd2;
        foreach (VEC[i]) begin
            sw_pulse(VEC[i][12]);
            rd(1'b0, v); check("R3 data walk", v, VEC[i][11:4]);
            rd(1'b1, v); check("R6 count walk", v, {4'h0, VEC[i][3:0]});
        end

        // R7: strobe source, latch follows MSB one clock later
        @(negedge clk);
        check("R7 strobe latch", {7'd0, dout_3w}, 8'h01);

        // R6: unselected timer pulse ignored
        tmr_pulse(1'b0);
        rd(1'b0, v); check("R6 timer ignored data", v, 8'hC3);
        rd(1'b1, v); check("R6 timer ignored count", v, 8'h08);

        // R6: timer source works, software ignored
        clk_src = 2'd1;
        tmr_pulse(1'b0);
        rd(1'b0, v); check("R6 timer shift", v, 8'h86);
        sw_pulse(1'b1);
        rd(1'b0, v); check("R6 soft ignored data", v, 8'h86);
        rd(1'b1, v); check("R6 soft ignored count", v, 8'h09);

        // R6: stopped source
        clk_src = 2'd3;
        sw_pulse(1'b1); tmr_pulse(1'b1);
        rd(1'b0, v); check("R6 none data", v, 8'h86);
        rd(1'b1, v); check("R6 none count", v, 8'h09);

        // R9: data write in the strobe cycle wins; counter still counts
        clk_src = 2'd2;
        @(negedge clk);
        di_pin = 1'b1; sw_strobe = 1'b1; bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = 8'h55;
        @(negedge clk);
        sw_strobe = 1'b0; bus_wr = 1'b0;
        rd(1'b0, v); check("R9 data write wins", v, 8'h55);
        rd(1'b1, v); check("R9 count alongside", v, 8'h0A);

        // R9: counter write in the strobe cycle wins; data still shifts
        @(negedge clk);
        di_pin = 1'b0; sw_strobe = 1'b1; bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 8'h03;
        @(negedge clk);
        sw_strobe = 1'b0; bus_wr = 1'b0;
        rd(1'b1, v); check("R9 count write wins", v, 8'h03);
        rd(1'b0, v); check("R9 shift alongside", v, 8'hAA);

        // R5: wrap sets a sticky flag
        wr(1'b1, 8'h0F);
        sw_pulse(1'b0);
        rd(1'b1, v); check("R5 wrap status", v, 8'h80);
        check("R5 irq", {7'd0, ovf_irq}, 8'h01);
        repeat (5) @(negedge clk);
        check("R5 irq sticky", {7'd0, ovf_irq}, 8'h01);

        // R2: write without clear bit keeps flag; with it clears
        wr(1'b1, 8'h05);
        rd(1'b1, v); check("R2 keep flag", v, 8'h85);
        wr(1'b1, 8'h80);
        rd(1'b1, v); check("R2 clear flag", v, 8'h00);

        // R4: external byte, 16 edges
        clk_src = 2'd0;
        sck_level(1'b1, 1'b0);
        rd(1'b1, v); check("R4 rise counts", v, 8'h01);
        sck_level(1'b0, 1'b0);
        rd(1'b1, v); check("R4 fall counts", v, 8'h02);
        for (int b = 1; b < 8; b++) begin
            sck_level(1'b1, (b >= 2 && b <= 5));
            sck_level(1'b0, 1'b0);
        end
        rd(1'b0, v); check("R4 ext byte", v, 8'h3C);
        rd(1'b1, v); check("R4 ext wrap", v, 8'h80);
        wr(1'b1, 8'h80);

        // R7/R8: latch loads only at the falling edge
        wr(1'b0, 8'hC0);
        check("R7 no load on write", {7'd0, dout_3w}, 8'h00);
        sck_level(1'b1, 1'b0);
        check("R7 hold after rise", {7'd0, dout_3w}, 8'h00);
        sck_level(1'b0, 1'b0);
        check("R7 load at fall", {7'd0, dout_3w}, 8'h01);
        wire_mode = 1'b1;
        #1;
        check("R8 two-wire dout", {7'd0, dout_3w}, 8'h00);
        check("R8 two-wire release", {7'd0, sda_drive_low}, 8'h00);
        sck_level(1'b1, 1'b0);
        sck_level(1'b0, 1'b0);
        check("R8 two-wire drive low", {7'd0, sda_drive_low}, 8'h01);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule